// File: doc/BRIEF.md
# Serial ADC frame controller

This block sits on the host side of a three-wire serial sampling converter. It drives a chip-select line and a serial clock and reads one serial data line. A start request lowers chip select, which makes the converter sample its input. The block then runs a frame of sixteen serial clock cycles and collects the converter's 12-bit result from the data line. It then returns chip select high and holds it high for a minimum quiet interval before any new frame can begin.

A second request puts the converter to sleep. It runs a deliberately truncated frame: chip select rises partway through, well inside the window the converter reads as a power-down command and well away from both of that window's edges. After a reset or a sleep, the converter's first conversion cannot be trusted. The next start request therefore runs a throw-away frame and then a real one back to back, and reports only the second.

The serial clock is the system clock divided by a programmable half-period. With a 160 MHz system clock and a half-period of 4, it stays within the converter's 20 MHz ceiling with an even duty cycle.

Top module: `adc_frame_ctrl`

## Requirements
- R1: A start request taken while idle lowers `cs_n_o`, produces exactly 16 falling edges on `sclk_o`, then raises `cs_n_o`. `busy_o` is 1 from the cycle after the request until the block is idle again.
- R2: Each high and low phase of `sclk_o` lasts `div_i` system clocks, and a value of 0 acts as 1. The first falling edge comes one half-period after `cs_n_o` falls. `sclk_o` is 1 whenever `cs_n_o` is 1.
- R3: `sdi_i` is captured at each falling edge of `sclk_o`. Of the 16 captured bits, the first four are leading zeros and are dropped. The remaining 12 form `result_o`, most significant bit first.
- R4: `valid_o` is high for exactly one system clock at the end of each reported conversion. `result_o` keeps its value until the next `valid_o` pulse.
- R5: A power-down request taken while idle produces a frame with exactly 4 falling edges on `sclk_o`, after which `cs_n_o` rises. No `valid_o` pulse follows, and `result_o` is unchanged.
- R6: The first start request after a reset or after a power-down frame runs two frames separated only by the quiet interval. Exactly one `valid_o` pulse follows, and it carries the second frame's data.
- R7: Between the rise of `cs_n_o` and its next fall there are at least `QUIET_CYC` (default 5) system clocks with `cs_n_o` high. Back-to-back frames use exactly that interval.
- R8: A start request that arrives while `busy_o` is 1 has no effect: no extra frame and no extra `valid_o`.
- R9: If start and power-down requests arrive in the same idle cycle, the power-down request is served and the start request is dropped.
- R10: During and after reset, `cs_n_o` and `sclk_o` are 1, `busy_o` and `valid_o` are 0, and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| pdown_i | input | 1 | Power-down request, sampled while idle |
| div_i | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1), held stable during a frame |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | RES_W | Last reported conversion result |
| valid_o | output | 1 | One-cycle strobe for a new `result_o` |
| busy_o | output | 1 | A frame or quiet interval is in progress |

## Verification
Two pairs of functions can coincide. The first is a start request and a power-down request in the same idle cycle. The bench raises both on the same system clock edge and expects one frame of exactly four falling edges and no strobe. It then expects the following start to run the throw-away frame plus the real frame. The second pair is a start request and a frame already in flight. The bench pulses start in the middle of a frame and counts frames and strobes afterwards, expecting exactly one of each.

// File: rtl/adc_frame_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial ADC frame controller.
package adc_frame_pkg;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // chip select high, waiting for a request
        ST_LEAD  = 2'd1,   // chip select low, serial clock still high
        ST_CLK   = 2'd2,   // serial clock toggling
        ST_QUIET = 2'd3    // chip select high, enforcing the gap
    } frm_state_t;

endpackage

// File: rtl/adc_tick_gen.sv
`timescale 1ns/1ps
// Half-period tick generator.
// Emits one-cycle ticks every half_i system clocks while run_i is high.
// A half_i of 0 is treated as 1. half_i is expected to be stable while run_i is high.
module adc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;

    // Clamp a zero setting to the shortest legal half-period.
    always_comb half_eff = (half_i == '0) ? DIV_W'(1) : half_i;

    // A tick marks the last system clock of a half-period.
    always_comb tick_o = run_i && (cnt_q >= half_eff - 1'b1);

    // Count system clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (tick_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/adc_shift_in.sv
`timescale 1ns/1ps
// Serial capture register.
// Shifts sdi_i in MSB first on every sample strobe. Because only the last RES_W
// bits are kept, any leading bits of a longer frame fall out of the register.
module adc_shift_in #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic             sdi_i,
    output logic [RES_W-1:0] word_o
);

    logic [RES_W-1:0] sh_q;

    // Shift one bit in at each serial clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (sample_i) sh_q <= {sh_q[RES_W-2:0], sdi_i};
    end

    always_comb word_o = sh_q;

endmodule

// File: rtl/adc_frame_fsm.sv
`timescale 1ns/1ps
// Frame sequencer.
// Owns chip select and the serial clock, counts falling edges, runs full and
// power-down frames, and inserts a throw-away frame after reset or sleep.
// Assumes ticks from adc_tick_gen, and QUIET_CYC >= 2 so that the result strobe
// falls inside the quiet interval.
module adc_frame_fsm
    import adc_frame_pkg::*;
#(
    parameter int FRAME_FALLS = 16,
    parameter int PD_FALLS    = 4,
    parameter int QUIET_CYC   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic pdown_i,
    input  logic tick_i,
    output logic run_o,
    output logic sample_o,
    output logic done_o,
    output logic cs_n_o,
    output logic sclk_o,
    output logic busy_o
);

    localparam int CNT_W = $clog2(FRAME_FALLS + 1);
    localparam int Q_W   = $clog2(QUIET_CYC + 1);
    localparam logic [CNT_W-1:0] FR_LAST = CNT_W'(FRAME_FALLS);
    localparam logic [CNT_W-1:0] PD_LAST = CNT_W'(PD_FALLS);
    localparam logic [Q_W-1:0]   Q_LAST  = Q_W'(QUIET_CYC - 1);

    frm_state_t       state_q;
    logic [CNT_W-1:0] fall_q;
    logic [Q_W-1:0]   qcnt_q;
    logic             cs_n_q, sclk_q;
    logic             pd_q;       // current frame is a power-down frame
    logic             discard_q;  // next conversion frame is a throw-away
    logic             again_q;    // re-run a frame after the quiet interval
    logic             done_q;

    // The divider runs while chip select is low.
    always_comb run_o = (state_q == ST_LEAD) || (state_q == ST_CLK);
    // Capture on the tick that drives the serial clock low.
    always_comb sample_o = run_o && tick_i && sclk_q;
    always_comb busy_o   = (state_q != ST_IDLE);
    always_comb cs_n_o   = cs_n_q;
    always_comb sclk_o   = sclk_q;
    always_comb done_o   = done_q;

    // Sequence the frames, the quiet gap and the throw-away handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            fall_q    <= '0;
            qcnt_q    <= '0;
            cs_n_q    <= 1'b1;
            sclk_q    <= 1'b1;
            pd_q      <= 1'b0;
            discard_q <= 1'b1;
            again_q   <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (pdown_i || start_i) begin
                        pd_q    <= pdown_i;
                        cs_n_q  <= 1'b0;
                        fall_q  <= '0;
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick_i) begin
                        sclk_q  <= 1'b0;
                        fall_q  <= fall_q + 1'b1;
                        state_q <= ST_CLK;
                    end
                end
                ST_CLK: begin
                    if (tick_i) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            fall_q <= fall_q + 1'b1;
                        end else if ((pd_q && fall_q == PD_LAST) ||
                                     (!pd_q && fall_q == FR_LAST)) begin
                            sclk_q  <= 1'b1;
                            cs_n_q  <= 1'b1;
                            qcnt_q  <= '0;
                            state_q <= ST_QUIET;
                            if (pd_q) begin
                                discard_q <= 1'b1;
                            end else if (discard_q) begin
                                discard_q <= 1'b0;
                                again_q   <= 1'b1;
                            end else begin
                                done_q <= 1'b1;
                            end
                        end else begin
                            sclk_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (qcnt_q == Q_LAST) begin
                        if (again_q) begin
                            again_q <= 1'b0;
                            pd_q    <= 1'b0;
                            cs_n_q  <= 1'b0;
                            fall_q  <= '0;
                            state_q <= ST_LEAD;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        qcnt_q <= qcnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R1: a frame never runs past its final falling edge.
    assert_fall_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q <= FR_LAST);

    // R1 R5: chip select rises only after the full count or the power-down count.
    assert_cs_rise_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> (pd_q ? (fall_q == PD_LAST) : (fall_q == FR_LAST)));

    // R2: the serial clock idles high while chip select is high.
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> sclk_q);

    // R2: the serial clock moves only at the end of a half-period.
    assert_sclk_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_q) |-> $past(tick_i));

endmodule

// File: rtl/adc_frame_ctrl.sv
`timescale 1ns/1ps
// Serial ADC frame controller, top level.
// Joins the half-period divider, the frame sequencer and the capture register,
// and registers the reported result with its one-cycle strobe.
// Assumes div_i is held stable while busy_o is high.
module adc_frame_ctrl #(
    parameter int RES_W       = 12,
    parameter int FRAME_FALLS = 16,
    parameter int PD_FALLS    = 4,
    parameter int DIV_W       = 8,
    parameter int QUIET_CYC   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pdown_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             sdi_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [RES_W-1:0] result_o,
    output logic             valid_o,
    output logic             busy_o
);

    localparam int HI_W = $clog2(QUIET_CYC + 1);

    logic             run, tick, sample, done;
    logic [RES_W-1:0] word;
    logic [RES_W-1:0] result_q;
    logic             valid_q;
    logic [HI_W-1:0]  hi_cnt_q;

    adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (div_i),
        .tick_o (tick)
    );

    adc_frame_fsm #(
        .FRAME_FALLS (FRAME_FALLS),
        .PD_FALLS    (PD_FALLS),
        .QUIET_CYC   (QUIET_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .pdown_i  (pdown_i),
        .tick_i   (tick),
        .run_o    (run),
        .sample_o (sample),
        .done_o   (done),
        .cs_n_o   (cs_n_o),
        .sclk_o   (sclk_o),
        .busy_o   (busy_o)
    );

    adc_shift_in #(.RES_W(RES_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .sdi_i    (sdi_i),
        .word_o   (word)
    );

    // Latch the captured word and strobe it once per reported conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= done;
            if (done) result_q <= word;
        end
    end

    always_comb result_o = result_q;
    always_comb valid_o  = valid_q;

    // Count high chip-select cycles, saturating, for the quiet-gap check.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hi_cnt_q <= HI_W'(QUIET_CYC);
        else if (!cs_n_o)                 hi_cnt_q <= '0;
        else if (hi_cnt_q != HI_W'(QUIET_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    // R4: the strobe lasts exactly one system clock.
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R4: the strobe comes while the quiet interval still holds busy high.
    assert_valid_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (busy_o && cs_n_o));

    // R4: the result changes only together with a strobe.
    assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> valid_o);

    // R7: chip select falls only after the full quiet interval.
    assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_cnt_q == HI_W'(QUIET_CYC)));

endmodule

// File: tb/adc_frame_ctrl_tb.sv
`timescale 1ns/1ps
module adc_frame_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        pdown_i = 1'b0;
    logic [7:0]  div_i = 8'd2;
    logic        sdi_i = 1'b0;
    logic        cs_n_o, sclk_o, valid_o, busy_o;
    logic [11:0] result_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    adc_frame_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pdown_i(pdown_i),
        .div_i(div_i), .sdi_i(sdi_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .result_o(result_o), .valid_o(valid_o), .busy_o(busy_o)
    );

    // Converter model: a zero after chip select falls, then the next bit after each fall.
    int          mframes = 0;
    int          base = 0;
    logic [11:0] v0 = '0, v1 = '0, cur = '0;
    int          nb = 0;
    always @(negedge cs_n_o or negedge sclk_o) begin
        if (sclk_o === 1'b1) begin
            cur = (mframes == base) ? v0 : v1;
            mframes++;
            nb = 0;
            #1 sdi_i = 1'b0;
        end else if (cs_n_o === 1'b0) begin
            nb++;
            #1 sdi_i = (nb < 4 || nb > 15) ? 1'b0 : cur[15-nb];
        end
    end

    // Pin monitor: frames, falls per frame, gaps, low phases, strobes.
    int frames = 0, falls = 0, last_falls = 0, hi = 0, last_gap = 0;
    int low = 0, last_low = 0, vcnt = 0, vlen = 0, last_vlen = 0;
    logic p_cs = 1'b1, p_sclk = 1'b1, p_v = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (p_cs && !cs_n_o) begin
                frames++; last_gap = hi; hi = 0; falls = 0;
            end else if (cs_n_o) hi++;
            if (!p_cs && cs_n_o) last_falls = falls;
            if (p_sclk && !sclk_o && !cs_n_o) falls++;
            if (!sclk_o) low++;
            if (!p_sclk && sclk_o) begin last_low = low; low = 0; end
            if (valid_o) begin vcnt++; vlen++; end
            else if (p_v) begin last_vlen = vlen; vlen = 0; end
        end
        p_cs = cs_n_o; p_sclk = sclk_o; p_v = valid_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle(input string tag);
        bit done = 0;
        for (int i = 0; i < 5000 && !done; i++) begin
            @(negedge clk);
            if (!busy_o) done = 1;
        end
        check(done, {tag, " timeout"}, 0, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_n_o === 1'b1 && sclk_o === 1'b1, "R10 cs/sclk at reset", {cs_n_o, sclk_o}, 3);
        check(busy_o === 1'b0 && valid_o === 1'b0, "R10 busy/valid at reset", {busy_o, valid_o}, 0);
        check(result_o === 12'h000, "R10 result at reset", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_conv(input logic [11:0] a, input logic [11:0] b,
                          input int nfr, input logic [7:0] dv, input string tag);
        int f0, c0, eff;
        eff = (dv == 0) ? 1 : int'(dv);
        div_i = dv; v0 = a; v1 = b; base = mframes;
        f0 = frames; c0 = vcnt;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(busy_o === 1'b1, {tag, " R1 busy after start"}, busy_o, 1);
        wait_idle(tag);
        check(frames - f0 == nfr, {tag, " R1 R6 frame count"}, frames - f0, nfr);
        check(vcnt - c0 == 1, {tag, " R4 R6 strobe count"}, vcnt - c0, 1);
        check(result_o == ((nfr == 2) ? b : a), {tag, " R3 result"}, result_o, (nfr == 2) ? b : a);
        check(last_falls == 16, {tag, " R1 falls per frame"}, last_falls, 16);
        check(last_vlen == 1, {tag, " R4 strobe width"}, last_vlen, 1);
        check(last_low == eff, {tag, " R2 low phase"}, last_low, eff);
        if (nfr == 2) check(last_gap == 5, {tag, " R7 back-to-back gap"}, last_gap, 5);
        else          check(last_gap >= 5, {tag, " R7 gap"}, last_gap, 5);
    endtask

    task automatic t_busy_ignore();
        int f0, c0;
        div_i = 8'd2; v0 = 12'h3C7; v1 = 12'h3C7; base = mframes;
        f0 = frames; c0 = vcnt;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        wait_idle("R8");
        check(frames - f0 == 1, "R8 start while busy adds no frame", frames - f0, 1);
        check(vcnt - c0 == 1, "R8 start while busy adds no strobe", vcnt - c0, 1);
        check(result_o == 12'h3C7, "R8 result", result_o, 12'h3C7);
    endtask

    task automatic t_pdown(input bit with_start, input string tag);
        int f0, c0;
        logic [11:0] keep;
        keep = result_o; f0 = frames; c0 = vcnt;
        v0 = 12'hBAD; v1 = 12'hBAD; base = mframes;
        @(negedge clk) begin pdown_i = 1'b1; start_i = with_start; end
        @(negedge clk) begin pdown_i = 1'b0; start_i = 1'b0; end
        wait_idle(tag);
        check(frames - f0 == 1, {tag, " one frame"}, frames - f0, 1);
        check(last_falls == 4, {tag, " four falls"}, last_falls, 4);
        check(vcnt - c0 == 0, {tag, " no strobe"}, vcnt - c0, 0);
        check(result_o == keep, {tag, " result kept"}, result_o, keep);
    endtask

    task automatic t_hold();
        logic [11:0] keep;
        keep = result_o;
        repeat (40) @(negedge clk);
        check(result_o == keep && !valid_o, "R4 result held while idle", result_o, keep);
    endtask

    initial begin
        t_reset();
        t_conv(12'h123, 12'hA5C, 2, 8'd2, "R6 first after reset");
        t_conv(12'hFFF, 12'h000, 1, 8'd1, "R2 div1");
        t_conv(12'h000, 12'hFFF, 1, 8'd3, "R3 zeros div3");
        t_conv(12'h801, 12'h000, 1, 8'd0, "R2 div0");
        t_hold();
        t_busy_ignore();
        t_pdown(1'b0, "R5 power-down");
        t_conv(12'h111, 12'h6E9, 2, 8'd2, "R6 after power-down");
        t_pdown(1'b1, "R9 start+pdown");
        t_conv(12'h222, 12'h5A3, 2, 8'd2, "R9 R6 recovery");
        t_conv(12'h001, 12'h000, 1, 8'd2, "R3 lsb");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

endmodule